// File: doc/BRIEF.md
# Debug Trigger Action Unit

This block sits between the address and data comparators of an on-chip debugger and the rest of the debug logic. Each cycle it receives match pulses from two comparators, A and B, and turns them into an action chosen by a programmed trigger mode. The four actions are a breakpoint request to the CPU, a one-shot capture of a data bus value for the trace buffer, the start of change-of-flow tracing, and the end of change-of-flow tracing. Comparator B can be qualified by a data compare. Two qualifier bits choose whether that compare, and any captured value, come from the CPU write data bus or the CPU read data bus.

A breakpoint is raised in one of two ways. A forced breakpoint is held pending until the current instruction completes, and then it is issued as a one-cycle request. A tagged breakpoint attaches a tag bit to the opcode being fetched. That bit travels through a shadow queue that tracks the CPU instruction queue. A one-cycle background-entry substitute signal is issued only when the tagged opcode reaches execution, so an opcode flushed by a change of flow produces nothing. The CPU, the trace storage and the host registers lie outside the block and appear only as ports.

Top module: `dbg_trig_unit`

## Requirements
- R1: The selected data bus is the write bus (`cpu_wdata`) when `rwq_en`=1 and `rw_sel`=0, and the read bus (`cpu_rdata`) in every other case. This bus is used both for the B data compare (B-full = `cmp_b_hit` and selected bus equals `b_data_ref`) and for the captured value.
- R2: The trigger mode (`mode_wdata`) and the tag/force choice (`tag_wdata`: 1 = tag, 0 = force) are latched only when a write of 1 to the arm bit finds the unit disarmed. Later changes, or repeated arm writes while armed, do not change them.
- R3: Breakpoint modes: 3'b000 fires on A, 3'b001 fires on A or B-full, 3'b010 fires on B-full. A B hit whose data does not match triggers nothing.
- R4: Capture modes: 3'b011 fires on A and 3'b100 fires on B (address only). `cap_valid` pulses for one cycle after the hit edge, and `cap_data` takes the selected bus value from that edge and holds it until the next capture. The unit stays armed.
- R5: Mode 3'b101 fires on A. `trace_run` goes to 1 and `trace_begin` pulses one cycle after the hit edge. Further hits give no further pulse, and the unit stays armed.
- R6: Modes 3'b110 (fires on A) and 3'b111 (fires on B-full) set `trace_run` when arming. A hit clears `trace_run`, pulses `trace_end` and disarms.
- R7: In force mode, a breakpoint hit sets a pending break. `brk_req` pulses for exactly one cycle after the first `instr_done` edge later than the hit edge.
- R8: In tag mode, a breakpoint hit counts only when it coincides with `fetch_valid`. The tag enters the shadow queue with that opcode. `bgnd_sub` pulses one cycle after the edge where that entry executes (`exec_valid` at the queue head), and `brk_req` is not raised.
- R9: `q_flush` discards every queued entry, so a flushed tagged opcode never produces `bgnd_sub`.
- R10: A breakpoint hit or an end-trace hit clears `armed`. A write of 0 to the arm bit clears `armed` and `trace_run`, and cancels a pending forced break. No trigger acts in a cycle that carries an arm write.
- R11: While `rst_n` is low, every output is 0.
- R12: While disarmed, comparator hits produce no capture, trace pulse or new breakpoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm_wr | input | 1 | Write strobe for the arm bit |
| arm_wdata | input | 1 | Arm value written |
| mode_wdata | input | 3 | Trigger mode, latched when arming |
| tag_wdata | input | 1 | 1 = tagged breakpoint, 0 = forced, latched when arming |
| rwq_en | input | 1 | Read/write qualify enable |
| rw_sel | input | 1 | Read/write select (0 = write) |
| cmp_a_hit | input | 1 | Comparator A address match |
| cmp_b_hit | input | 1 | Comparator B address match |
| b_data_ref | input | DW | Comparator B data reference |
| cpu_rdata | input | DW | CPU read data bus |
| cpu_wdata | input | DW | CPU write data bus |
| fetch_valid | input | 1 | Opcode enters the instruction queue |
| exec_valid | input | 1 | Queue head opcode executes |
| q_flush | input | 1 | Instruction queue flushed by a change of flow |
| instr_done | input | 1 | Current instruction completes |
| armed | output | 1 | Arm bit state |
| trace_run | output | 1 | Change-of-flow tracing active |
| trace_begin | output | 1 | Begin-trace pulse |
| trace_end | output | 1 | End-trace pulse |
| cap_valid | output | 1 | Capture strobe to trace storage |
| cap_data | output | DW | Captured bus value |
| brk_req | output | 1 | Forced breakpoint request pulse |
| bgnd_sub | output | 1 | Background-entry substitute for an executed tagged opcode |

## Verification
Capture, trace begin, trace end and disarm all appear one edge after the hit edge. A forced break appears one edge after the first later `instr_done`, and a tag substitute appears one edge after the executing edge. The bench drives inputs 1 ns after a rising edge and advances a cycle model in the bench by the same rules. It then compares every output 1 ns after the following edge, so each result is sampled in exactly the cycle it is due. Directed sequences cover the bus-select combinations, mode latching, tag flushing and manual disarm. These are followed by seeded random traffic that mixes arming, hits, fetch, execute and flush.

// File: rtl/dbg_trig_pkg.sv
// Shared types for the debug trigger action unit.
// Assumes a 3-bit trigger mode field; every encoding has a meaning.
package dbg_trig_pkg;

    typedef enum logic [2:0] {
        TM_BRK_A       = 3'd0,
        TM_BRK_A_OR_BF = 3'd1,
        TM_BRK_BF      = 3'd2,
        TM_CAP_A       = 3'd3,
        TM_CAP_B       = 3'd4,
        TM_BEGIN_A     = 3'd5,
        TM_END_A       = 3'd6,
        TM_END_BF      = 3'd7
    } trig_mode_e;

    typedef struct packed {
        logic brk;
        logic cap;
        logic begin_tr;
        logic end_tr;
    } trig_act_t;

    function automatic logic mode_is_end(input logic [2:0] m);
        return (m == TM_END_A) || (m == TM_END_BF);
    endfunction

endpackage

// File: rtl/dbg_data_sel.sv
// Data bus selector and comparator B data compare.
// Picks the write bus only for qualify-enabled write accesses, otherwise the
// read bus. Purely combinational; assumes buses are stable around the edge.
module dbg_data_sel #(
    parameter int DW = 8
) (
    input  logic          qual_en,
    input  logic          rw_sel,
    input  logic [DW-1:0] rdata,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] ref_val,
    output logic [DW-1:0] sel_data,
    output logic          data_eq
);

    logic use_wr;

    // choose the bus that feeds the compare and the capture path
    always_comb begin
        use_wr   = qual_en && !rw_sel;
        sel_data = use_wr ? wdata : rdata;
        data_eq  = (sel_data == ref_val);
    end

endmodule

// File: rtl/dbg_trig_decode.sv
// Maps the latched trigger mode and comparator hits to one action class.
// Combinational; gating by the arm state is done by the caller.
module dbg_trig_decode
    import dbg_trig_pkg::*;
(
    input  trig_mode_e mode,
    input  logic       hit_a,
    input  logic       hit_b,
    input  logic       hit_bf,
    output trig_act_t  act
);

    // decode the mode into the requested action
    always_comb begin
        act = '0;
        unique case (mode)
            TM_BRK_A:       act.brk      = hit_a;
            TM_BRK_A_OR_BF: act.brk      = hit_a | hit_bf;
            TM_BRK_BF:      act.brk      = hit_bf;
            TM_CAP_A:       act.cap      = hit_a;
            TM_CAP_B:       act.cap      = hit_b;
            TM_BEGIN_A:     act.begin_tr = hit_a;
            TM_END_A:       act.end_tr   = hit_a;
            TM_END_BF:      act.end_tr   = hit_bf;
            default:        act          = '0;
        endcase
    end

endmodule

// File: rtl/dbg_tag_queue.sv
// Shadow queue of breakpoint tag bits, one per opcode held in the CPU
// instruction queue. Push on fetch, pop on execute, flush clears all.
// Assumes the CPU never executes from an empty queue; such pops are ignored.
// A push into a full queue without a pop is dropped.
module dbg_tag_queue #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic push_tag,
    input  logic pop,
    input  logic flush,
    output logic head_valid,
    output logic head_tag,
    output logic full
);

    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0]    cnt;
    logic [DEPTH-1:0] tags;
    logic             do_pop;
    logic             do_push;
    logic [CW-1:0]    wr_idx;

    // handshake qualification and write slot
    always_comb begin
        head_valid = (cnt != '0);
        full       = (cnt == CW'(DEPTH));
        do_pop     = pop && head_valid;
        do_push    = push && (!full || do_pop);
        wr_idx     = do_pop ? cnt - 1'b1 : cnt;
        head_tag   = tags[0] && head_valid;
    end

    // occupancy counter
    always_ff @(posedge clk) begin
        if (!rst_n || flush)
            cnt <= '0;
        else if (do_push && !do_pop)
            cnt <= cnt + 1'b1;
        else if (do_pop && !do_push)
            cnt <= cnt - 1'b1;
    end

    // one storage slot per queue entry, shifting toward the head
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic shift_src;
        if (i < DEPTH - 1) begin : g_mid
            assign shift_src = tags[i+1];
        end else begin : g_last
            assign shift_src = 1'b0;
        end

        // update slot i from its neighbour or the incoming tag
        always_ff @(posedge clk) begin
            if (!rst_n || flush)
                tags[i] <= 1'b0;
            else if (do_push && (wr_idx == CW'(i)))
                tags[i] <= push_tag;
            else if (do_pop)
                tags[i] <= shift_src;
        end
    end

endmodule

// File: rtl/dbg_trig_unit.sv
// Debug trigger action unit (top).
// Turns comparator hits into breakpoint, capture, begin-trace or end-trace
// actions according to a mode latched at arming. Forced breaks wait for the
// end of the current instruction; tagged breaks ride a shadow tag queue and
// act only when the tagged opcode executes. Assumes comparator hits, bus
// values and CPU pipeline strobes are synchronous to clk.
module dbg_trig_unit
    import dbg_trig_pkg::*;
#(
    parameter int DW     = 8,
    parameter int QDEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm_wr,
    input  logic          arm_wdata,
    input  logic [2:0]    mode_wdata,
    input  logic          tag_wdata,
    input  logic          rwq_en,
    input  logic          rw_sel,
    input  logic          cmp_a_hit,
    input  logic          cmp_b_hit,
    input  logic [DW-1:0] b_data_ref,
    input  logic [DW-1:0] cpu_rdata,
    input  logic [DW-1:0] cpu_wdata,
    input  logic          fetch_valid,
    input  logic          exec_valid,
    input  logic          q_flush,
    input  logic          instr_done,
    output logic          armed,
    output logic          trace_run,
    output logic          trace_begin,
    output logic          trace_end,
    output logic          cap_valid,
    output logic [DW-1:0] cap_data,
    output logic          brk_req,
    output logic          bgnd_sub
);

    trig_mode_e    mode_q;
    logic          tag_q;
    logic          pend_q;
    logic [DW-1:0] sel_data;
    logic          data_eq;
    logic          hit_bf;
    trig_act_t     act;
    logic          live;
    logic          arm_rise;
    logic          disarm_wr;
    logic          brk_hit;
    logic          force_trig;
    logic          tag_trig;
    logic          cap_trig;
    logic          begin_trig;
    logic          end_trig;
    logic          q_head_valid;
    logic          q_head_tag;
    logic          q_full;

    dbg_data_sel #(.DW(DW)) i_sel (
        .qual_en  (rwq_en),
        .rw_sel   (rw_sel),
        .rdata    (cpu_rdata),
        .wdata    (cpu_wdata),
        .ref_val  (b_data_ref),
        .sel_data (sel_data),
        .data_eq  (data_eq)
    );

    assign hit_bf = cmp_b_hit && data_eq;

    dbg_trig_decode i_dec (
        .mode   (mode_q),
        .hit_a  (cmp_a_hit),
        .hit_b  (cmp_b_hit),
        .hit_bf (hit_bf),
        .act    (act)
    );

    // qualify the decoded action with the arm state and tag/force choice
    always_comb begin
        arm_rise   = arm_wr && arm_wdata && !armed;
        disarm_wr  = arm_wr && !arm_wdata;
        live       = armed && !arm_wr;
        brk_hit    = live && act.brk;
        force_trig = brk_hit && !tag_q;
        tag_trig   = brk_hit && tag_q && fetch_valid;
        cap_trig   = live && act.cap;
        begin_trig = live && act.begin_tr;
        end_trig   = live && act.end_tr;
    end

    dbg_tag_queue #(.DEPTH(QDEPTH)) i_tagq (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (fetch_valid),
        .push_tag   (tag_trig),
        .pop        (exec_valid),
        .flush      (q_flush),
        .head_valid (q_head_valid),
        .head_tag   (q_head_tag),
        .full       (q_full)
    );

    // arm bit: host writes win, breakpoint and end-trace hits self-clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b0;
        else if (arm_wr)
            armed <= arm_wdata;
        else if (force_trig || tag_trig || end_trig)
            armed <= 1'b0;
    end

    // mode and tag/force choice latched only on the disarmed-to-armed step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= TM_BRK_A;
            tag_q  <= 1'b0;
        end else if (arm_rise) begin
            mode_q <= trig_mode_e'(mode_wdata);
            tag_q  <= tag_wdata;
        end
    end

    // pending forced break held until the current instruction completes
    always_ff @(posedge clk) begin
        if (!rst_n || arm_wr)
            pend_q <= 1'b0;
        else if (force_trig)
            pend_q <= 1'b1;
        else if (instr_done)
            pend_q <= 1'b0;
    end

    // one-cycle break request and background substitute pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_req  <= 1'b0;
            bgnd_sub <= 1'b0;
        end else begin
            brk_req  <= pend_q && instr_done && !arm_wr;
            bgnd_sub <= exec_valid && q_head_valid && q_head_tag;
        end
    end

    // change-of-flow trace run flag and its edge pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trace_run   <= 1'b0;
            trace_begin <= 1'b0;
            trace_end   <= 1'b0;
        end else begin
            trace_begin <= begin_trig && !trace_run;
            trace_end   <= end_trig;
            if (disarm_wr)
                trace_run <= 1'b0;
            else if (arm_rise)
                trace_run <= mode_is_end(mode_wdata);
            else if (begin_trig)
                trace_run <= 1'b1;
            else if (end_trig)
                trace_run <= 1'b0;
        end
    end

    // data capture strobe and held value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_valid <= 1'b0;
            cap_data  <= '0;
        end else begin
            cap_valid <= cap_trig;
            if (cap_trig)
                cap_data <= sel_data;
        end
    end

    logic unused_full;
    assign unused_full = q_full;

endmodule

// File: rtl/dbg_trig_unit_chk.sv
// Temporal checks for dbg_trig_unit, attached with bind.
module dbg_trig_unit_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          arm_wr,
    input logic          rwq_en,
    input logic          rw_sel,
    input logic [DW-1:0] cpu_rdata,
    input logic [DW-1:0] cpu_wdata,
    input logic          exec_valid,
    input logic          q_flush,
    input logic          instr_done,
    input logic          armed,
    input logic          trace_run,
    input logic          trace_begin,
    input logic          trace_end,
    input logic          cap_valid,
    input logic [DW-1:0] cap_data,
    input logic          brk_req,
    input logic          bgnd_sub
);

    // R1: captured value comes from the bus selected at the hit edge
    assert_cap_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |-> cap_data == (($past(rwq_en) && !$past(rw_sel)) ? $past(cpu_wdata) : $past(cpu_rdata)));

    // R7: forced break follows an instruction completion
    assert_force_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> $past(instr_done));

    // R7: break request is a single-cycle pulse
    assert_brk_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |=> !brk_req);

    // R8: substitute appears only after an execute strobe
    assert_bgnd_exec_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bgnd_sub |-> $past(exec_valid));

    // R9: execute right after a flush finds no tagged entry
    assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q_flush ##1 exec_valid |=> !bgnd_sub);

    // R5: begin pulse coincides with an active trace
    assert_begin_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trace_begin |-> trace_run);

    // R6: end pulse leaves trace stopped and unit disarmed
    assert_end_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trace_end |-> (!trace_run && !armed));

    // R12: nothing fires from a disarmed cycle without an arm write
    assert_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(armed) && !$past(arm_wr)) |-> (!cap_valid && !trace_begin && !trace_end));

endmodule

bind dbg_trig_unit dbg_trig_unit_chk #(.DW(DW)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm_wr      (arm_wr),
    .rwq_en      (rwq_en),
    .rw_sel      (rw_sel),
    .cpu_rdata   (cpu_rdata),
    .cpu_wdata   (cpu_wdata),
    .exec_valid  (exec_valid),
    .q_flush     (q_flush),
    .instr_done  (instr_done),
    .armed       (armed),
    .trace_run   (trace_run),
    .trace_begin (trace_begin),
    .trace_end   (trace_end),
    .cap_valid   (cap_valid),
    .cap_data    (cap_data),
    .brk_req     (brk_req),
    .bgnd_sub    (bgnd_sub)
);

// File: tb/test_dbg_trig_unit.sv
module test_dbg_trig_unit;

    localparam int DW     = 8;
    localparam int QDEPTH = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          arm_wr, arm_wdata, tag_wdata;
    logic [2:0]    mode_wdata;
    logic          rwq_en, rw_sel, cmp_a_hit, cmp_b_hit;
    logic [DW-1:0] b_data_ref, cpu_rdata, cpu_wdata;
    logic          fetch_valid, exec_valid, q_flush, instr_done;
    logic          armed, trace_run, trace_begin, trace_end, cap_valid;
    logic [DW-1:0] cap_data;
    logic          brk_req, bgnd_sub;

    int total = 0;
    int bad   = 0;

    // bench model state
    bit       m_armed, m_tag, m_pend, m_run;
    bit [2:0] m_mode;
    bit [7:0] m_cdata;
    bit       m_q[$];

    always #5 clk = ~clk;

    dbg_trig_unit #(.DW(DW), .QDEPTH(QDEPTH)) i_dbg_trig_unit (
        .clk(clk), .rst_n(rst_n), .arm_wr(arm_wr), .arm_wdata(arm_wdata),
        .mode_wdata(mode_wdata), .tag_wdata(tag_wdata), .rwq_en(rwq_en),
        .rw_sel(rw_sel), .cmp_a_hit(cmp_a_hit), .cmp_b_hit(cmp_b_hit),
        .b_data_ref(b_data_ref), .cpu_rdata(cpu_rdata), .cpu_wdata(cpu_wdata),
        .fetch_valid(fetch_valid), .exec_valid(exec_valid), .q_flush(q_flush),
        .instr_done(instr_done), .armed(armed), .trace_run(trace_run),
        .trace_begin(trace_begin), .trace_end(trace_end), .cap_valid(cap_valid),
        .cap_data(cap_data), .brk_req(brk_req), .bgnd_sub(bgnd_sub)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        arm_wr = 0; arm_wdata = 0; tag_wdata = 0; mode_wdata = 0;
        cmp_a_hit = 0; cmp_b_hit = 0;
        fetch_valid = 0; exec_valid = 0; q_flush = 0; instr_done = 0;
    endtask

    function automatic bit [7:0] sel_bus(bit qen, bit rs, bit [7:0] rd, bit [7:0] wd);
        return (qen && !rs) ? wd : rd;
    endfunction

    // advance the model by one edge and compare every output after the edge
    task automatic tick();
        bit [7:0] sel;
        bit bf, bh, act, ft, tt, ct, bt, et;
        bit e_brk, e_bgnd, e_tb;
        int cnt;
        bit pop;
        sel = sel_bus(rwq_en, rw_sel, cpu_rdata, cpu_wdata);
        bf  = cmp_b_hit && (sel == b_data_ref);
        act = m_armed && !arm_wr;
        case (m_mode)
            3'd0: bh = cmp_a_hit;
            3'd1: bh = cmp_a_hit || bf;
            3'd2: bh = bf;
            default: bh = 0;
        endcase
        ft = act && bh && !m_tag;
        tt = act && bh && m_tag && fetch_valid;
        ct = act && ((m_mode == 3 && cmp_a_hit) || (m_mode == 4 && cmp_b_hit));
        bt = act && m_mode == 5 && cmp_a_hit;
        et = act && ((m_mode == 6 && cmp_a_hit) || (m_mode == 7 && bf));
        cnt    = m_q.size();
        e_brk  = m_pend && instr_done && !arm_wr;
        e_bgnd = exec_valid && cnt > 0 && m_q[0];
        e_tb   = bt && !m_run;
        if (ct) m_cdata = sel;
        // trace run
        if (arm_wr && !arm_wdata) m_run = 0;
        else if (arm_wr && arm_wdata && !m_armed) m_run = (mode_wdata >= 6);
        else if (bt) m_run = 1;
        else if (et) m_run = 0;
        // pending force
        if (arm_wr) m_pend = 0;
        else if (ft) m_pend = 1;
        else if (instr_done) m_pend = 0;
        // latch and arm
        if (arm_wr && arm_wdata && !m_armed) begin
            m_mode = mode_wdata;
            m_tag  = tag_wdata;
        end
        if (arm_wr) m_armed = arm_wdata;
        else if (ft || tt || et) m_armed = 0;
        // shadow queue
        if (q_flush) m_q.delete();
        else begin
            pop = exec_valid && cnt > 0;
            if (pop) void'(m_q.pop_front());
            if (fetch_valid && (cnt < QDEPTH || pop)) m_q.push_back(tt);
        end
        @(posedge clk);
        #1;
        check(armed == m_armed, "R10", "armed", armed, m_armed);
        check(brk_req == e_brk, "R7", "brk_req", brk_req, e_brk);
        check(bgnd_sub == e_bgnd, "R8", "bgnd_sub", bgnd_sub, e_bgnd);
        check(cap_valid == ct, "R4", "cap_valid", cap_valid, ct);
        check(cap_data == m_cdata, "R1", "cap_data", cap_data, m_cdata);
        check(trace_begin == e_tb, "R5", "trace_begin", trace_begin, e_tb);
        check(trace_end == et, "R6", "trace_end", trace_end, et);
        check(trace_run == m_run, "R6", "trace_run", trace_run, m_run);
    endtask

    task automatic do_arm(input bit [2:0] m, input bit t);
        arm_wr = 1; arm_wdata = 1; mode_wdata = m; tag_wdata = t;
        tick();
        arm_wr = 0; arm_wdata = 0;
    endtask

    task automatic do_disarm();
        arm_wr = 1; arm_wdata = 0;
        tick();
        arm_wr = 0;
    endtask

    initial begin
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        idle();
        rwq_en = 0; rw_sel = 0; b_data_ref = 8'h5A; cpu_rdata = 0; cpu_wdata = 0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1;
        // R11: reset state
        check({armed, trace_run, trace_begin, trace_end, cap_valid, brk_req, bgnd_sub} == 7'b0,
              "R11", "outputs in reset", {armed, trace_run, cap_valid, brk_req, bgnd_sub}, 0);
        check(cap_data == 0, "R11", "cap_data in reset", cap_data, 0);
        rst_n = 1;
        tick();

        // R1: bus selection for each qualifier combination, capture on A
        do_arm(3'd3, 0);
        cpu_rdata = 8'h11; cpu_wdata = 8'h22;
        rwq_en = 1; rw_sel = 0; cmp_a_hit = 1; tick();
        check(cap_data == 8'h22, "R1", "write bus chosen", cap_data, 8'h22);
        rwq_en = 1; rw_sel = 1; tick();
        check(cap_data == 8'h11, "R1", "read bus when rw_sel=1", cap_data, 8'h11);
        rwq_en = 0; rw_sel = 0; cpu_rdata = 8'h33; tick();
        check(cap_data == 8'h33, "R1", "read bus when qualify off", cap_data, 8'h33);
        cmp_a_hit = 0;

        // R2: mode change while armed has no effect
        arm_wr = 1; arm_wdata = 1; mode_wdata = 3'd0; tag_wdata = 0; tick();
        arm_wr = 0; mode_wdata = 3'd6;
        cmp_a_hit = 1; tick(); cmp_a_hit = 0;
        check(cap_valid == 1 && armed == 1, "R2", "still capture mode", {cap_valid, armed}, 3);
        do_disarm();

        // R12: disarmed hits ignored
        cmp_a_hit = 1; cmp_b_hit = 1; tick();
        check(cap_valid == 0 && trace_begin == 0 && armed == 0, "R12", "disarmed hit",
              {cap_valid, trace_begin, armed}, 0);
        cmp_a_hit = 0; cmp_b_hit = 0;

        // R3: B hit with data mismatch does nothing, match fires
        do_arm(3'd2, 0);
        cmp_b_hit = 1; cpu_rdata = 8'h00; tick();
        check(armed == 1, "R3", "mismatch keeps armed", armed, 1);
        do_disarm();
        do_arm(3'd1, 0);
        cpu_rdata = 8'h5A; tick(); cmp_b_hit = 0;
        check(armed == 0, "R3", "B-full fires break", armed, 0);
        tick();
        check(brk_req == 0, "R7", "no request before done", brk_req, 0);
        instr_done = 1; tick(); instr_done = 0;
        check(brk_req == 1, "R7", "request after done", brk_req, 1);
        tick();
        check(brk_req == 0, "R7", "single pulse", brk_req, 0);

        // R10: manual disarm cancels pending forced break
        do_arm(3'd0, 0);
        cmp_a_hit = 1; tick(); cmp_a_hit = 0;
        arm_wr = 1; arm_wdata = 0; tick(); arm_wr = 0;
        instr_done = 1; tick(); instr_done = 0;
        check(brk_req == 0, "R10", "cancelled break", brk_req, 0);

        // R8: tagged opcode executes
        q_flush = 1; tick(); q_flush = 0;
        do_arm(3'd0, 1);
        cmp_a_hit = 1; tick();
        check(armed == 1, "R8", "hit without fetch ignored", armed, 1);
        fetch_valid = 1; tick(); cmp_a_hit = 0;
        tick(); fetch_valid = 0;
        exec_valid = 1; tick();
        check(bgnd_sub == 1 && brk_req == 0, "R8", "tagged execute", {bgnd_sub, brk_req}, 2);
        tick(); exec_valid = 0;
        check(bgnd_sub == 0, "R8", "untagged execute", bgnd_sub, 0);

        // R9: tagged opcode flushed
        do_arm(3'd0, 1);
        cmp_a_hit = 1; fetch_valid = 1; tick(); cmp_a_hit = 0; fetch_valid = 0;
        q_flush = 1; tick(); q_flush = 0;
        exec_valid = 1; tick(); exec_valid = 0;
        check(bgnd_sub == 0, "R9", "flushed tag", bgnd_sub, 0);

        // R5 / R6: begin and end trace
        do_arm(3'd5, 0);
        cmp_a_hit = 1; tick();
        check(trace_begin == 1 && trace_run == 1, "R5", "begin", {trace_begin, trace_run}, 3);
        tick();
        check(trace_begin == 0 && armed == 1, "R5", "no repeat", {trace_begin, armed}, 1);
        cmp_a_hit = 0;
        do_disarm();
        check(trace_run == 0, "R10", "disarm stops trace", trace_run, 0);
        do_arm(3'd6, 0);
        check(trace_run == 1, "R6", "end mode runs", trace_run, 1);
        cmp_a_hit = 1; tick(); cmp_a_hit = 0;
        check(trace_end == 1 && trace_run == 0 && armed == 0, "R6", "end",
              {trace_end, trace_run, armed}, 4);

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            arm_wr      = ($urandom % 12) == 0;
            arm_wdata   = ($urandom % 4) != 0;
            mode_wdata  = 3'($urandom);
            tag_wdata   = $urandom % 2;
            rwq_en      = $urandom % 2;
            rw_sel      = $urandom % 2;
            cmp_a_hit   = ($urandom % 5) == 0;
            cmp_b_hit   = ($urandom % 4) == 0;
            b_data_ref  = 8'($urandom % 3);
            cpu_rdata   = 8'($urandom % 3);
            cpu_wdata   = 8'($urandom % 3);
            fetch_valid = (($urandom % 2) == 0) && (m_q.size() < QDEPTH);
            exec_valid  = ($urandom % 3) == 0;
            q_flush     = ($urandom % 20) == 0;
            instr_done  = ($urandom % 3) == 0;
            tick();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule